// File: doc/BRIEF.md
# Sequential Line Prefetch Generator

This block sits beside a cache and turns each demand line address into a short burst of prefetch line addresses for the next memory level. In sequential mode a demand for line X yields X+1, X+2, and so on up to X+D. D is the depth, a run-time input that is sampled when the demand arrives and capped at a design parameter. In adjacent mode the same demand yields one request only, for the partner line X XOR 1. No request ever leaves the page that holds X. A candidate that would cross the page edge is dropped.

Requests leave one per cycle on a valid/ready stream. While `pf_valid` is high and `pf_ready` is low, the offered line is held. It may be withdrawn without a handshake in two cases: a new demand arrives, which cancels the rest of the current run, or `enable` falls, which discards the run. A small first-in-first-out record of recently issued lines blocks repeats. When a candidate matches a recorded line, that candidate is skipped and takes one cycle with no output. The demand side carries valid only. It is always accepted, and a demand that arrives while `enable` is low is ignored.

Top module: `pnl_prefetcher`

## Requirements
- R1: In sequential mode, a demand for line X produces requests for X+1 through X+D in strictly ascending order, with the first request offered in the cycle after the demand is sampled.
- R2: Depth D is sampled together with the demand. A value above MAX_DEPTH is treated as MAX_DEPTH, and a value of 0 produces no request in sequential mode.
- R3: When `adj_mode` is 1 at the demand, the only request is X XOR 1 (bit 0 flipped), and depth is ignored.
- R4: Every request lies in the same page as X, where the page number is the line address above its low PAGE_LINES_LOG2 bits (6 by default, so 64 lines per page). Candidates past the last line of the page are dropped.
- R5: A demand that arrives while a run is in progress discards the remaining lines of that run and starts the new run in the next cycle.
- R6: An offered request keeps `pf_valid` high and `pf_line` unchanged until `pf_ready` accepts it, unless a new demand arrives or `enable` falls. At most one request is transferred per cycle.
- R7: A candidate equal to any of the last FILT_DEPTH accepted lines is not offered. It is skipped in one cycle with `pf_valid` low.
- R8: While `enable` is low, `pf_valid` is 0, demands are ignored, and any run in progress is discarded.
- R9: After reset, `pf_valid` is 0 until a demand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Prefetch on/off |
| adj_mode | input | 1 | 1 = partner-line mode, 0 = sequential mode; sampled at a demand |
| depth | input | DEPTH_W | Sequential run length; sampled at a demand |
| dmd_valid | input | 1 | Demand line present this cycle |
| dmd_line | input | LINE_W | Demand line address |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Downstream accepts the offered request |
| pf_line | output | LINE_W | Prefetch line address |

## Verification
The stability property assumes that no demand arrives and that `enable` does not fall while a request waits. Each of those events is a legal way to withdraw the request, so the property excludes both cases explicitly. The ordering, page and depth properties assume that the demand line, mode and depth are valid whenever `dmd_valid` is high. The stimulus drives these inputs only around a single-cycle demand pulse and holds them steady otherwise. The bench toggles `pf_ready` irregularly and places demands mid-run, so the withdrawal paths are exercised and not just assumed.

// File: rtl/pnl_pkg.sv
package pnl_pkg;
  typedef enum logic {
    RUN_SEQ = 1'b0,
    RUN_ADJ = 1'b1
  } run_mode_e;

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/pnl_run_gen.sv
module pnl_run_gen
  import pnl_pkg::*;
#(
  parameter int LINE_W          = 32,
  parameter int PAGE_LINES_LOG2 = 6,
  parameter int MAX_DEPTH       = 8,
  localparam int DEPTH_W        = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic [LINE_W-1:0] start_line,
  input  run_mode_e         mode,
  input  logic [DEPTH_W-1:0] depth,
  input  logic              advance,
  output logic [LINE_W-1:0] cur_line,
  output logic              busy
);
  localparam int PAGE_LINES = 1 << PAGE_LINES_LOG2;

  logic [DEPTH_W-1:0] rem_q;
  logic [LINE_W-1:0]  line_q;
  logic [DEPTH_W-1:0] run_len;
  logic [LINE_W-1:0]  first_line;
  int unsigned        room;
  int unsigned        want;

  // lines left above the demand inside its page
  always_comb begin
    room = PAGE_LINES - 1 - int'(start_line[PAGE_LINES_LOG2-1:0]);
    want = min_u(int'(depth), MAX_DEPTH);
    if (mode == RUN_ADJ) begin
      run_len    = DEPTH_W'(1);
      first_line = start_line ^ LINE_W'(1);
    end else begin
      run_len    = DEPTH_W'(min_u(want, room));
      first_line = start_line + LINE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      line_q <= '0;
    end else if (!enable) begin
      rem_q  <= '0;
    end else if (start) begin
      rem_q  <= run_len;
      line_q <= first_line;
    end else if (advance && rem_q != '0) begin
      rem_q  <= rem_q - DEPTH_W'(1);
      line_q <= line_q + LINE_W'(1);
    end
  end

  assign cur_line = line_q;
  assign busy     = (rem_q != '0);
endmodule

// File: rtl/pnl_recent_filter.sv
module pnl_recent_filter #(
  parameter int LINE_W     = 32,
  parameter int FILT_DEPTH = 4,
  localparam int PTR_W     = (FILT_DEPTH > 1) ? $clog2(FILT_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] probe_line,
  output logic              hit,
  input  logic              push,
  input  logic [LINE_W-1:0] push_line
);
  logic [LINE_W-1:0]     ent_q [FILT_DEPTH];
  logic [FILT_DEPTH-1:0] vld_q;
  logic [FILT_DEPTH-1:0] match;
  logic [PTR_W-1:0]      wr_q;

  for (genvar g = 0; g < FILT_DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (ent_q[g] == probe_line);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        ent_q[g] <= '0;
      end else if (push && int'(wr_q) == g) begin
        vld_q[g] <= 1'b1;
        ent_q[g] <= push_line;
      end
    end
  end

  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (push) begin
      wr_q <= (int'(wr_q) == FILT_DEPTH - 1) ? '0 : wr_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/pnl_prefetcher.sv
module pnl_prefetcher
  import pnl_pkg::*;
#(
  parameter int LINE_W          = 32,
  parameter int PAGE_LINES_LOG2 = 6,
  parameter int MAX_DEPTH       = 8,
  parameter int FILT_DEPTH      = 4,
  localparam int DEPTH_W        = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               adj_mode,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               dmd_valid,
  input  logic [LINE_W-1:0]  dmd_line,
  output logic               pf_valid,
  input  logic               pf_ready,
  output logic [LINE_W-1:0]  pf_line
);
  logic              busy;
  logic              hit;
  logic              skip;
  logic              xfer;
  logic [LINE_W-1:0] cand;
  run_mode_e         mode;

  assign mode = adj_mode ? RUN_ADJ : RUN_SEQ;

  pnl_run_gen #(
    .LINE_W(LINE_W), .PAGE_LINES_LOG2(PAGE_LINES_LOG2), .MAX_DEPTH(MAX_DEPTH)
  ) gen_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .start(dmd_valid), .start_line(dmd_line), .mode(mode), .depth(depth),
    .advance(xfer || skip), .cur_line(cand), .busy(busy)
  );

  pnl_recent_filter #(
    .LINE_W(LINE_W), .FILT_DEPTH(FILT_DEPTH)
  ) filt_i (
    .clk(clk), .rst_n(rst_n), .probe_line(cand), .hit(hit),
    .push(xfer), .push_line(cand)
  );

  assign pf_valid = enable && busy && !hit;
  assign skip     = enable && busy && hit;
  assign xfer     = pf_valid && pf_ready;
  assign pf_line  = cand;
endmodule

// File: rtl/pnl_checker.sv
module pnl_checker #(
  parameter int LINE_W          = 32,
  parameter int PAGE_LINES_LOG2 = 6,
  parameter int MAX_DEPTH       = 8,
  localparam int DEPTH_W        = $clog2(MAX_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               enable,
  input logic               adj_mode,
  input logic [DEPTH_W-1:0] depth,
  input logic               dmd_valid,
  input logic [LINE_W-1:0]  dmd_line,
  input logic               pf_valid,
  input logic               pf_ready,
  input logic [LINE_W-1:0]  pf_line
);
  logic [LINE_W-1:0]  base_q;
  logic [LINE_W-1:0]  last_q;
  logic               have_last_q;
  logic               adj_q;
  logic [DEPTH_W-1:0] dep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q      <= '0;
      last_q      <= '0;
      have_last_q <= 1'b0;
      adj_q       <= 1'b0;
      dep_q       <= '0;
    end else if (enable && dmd_valid) begin
      base_q      <= dmd_line;
      adj_q       <= adj_mode;
      dep_q       <= (int'(depth) > MAX_DEPTH) ? DEPTH_W'(MAX_DEPTH) : depth;
      have_last_q <= 1'b0;
    end else if (pf_valid && pf_ready) begin
      last_q      <= pf_line;
      have_last_q <= 1'b1;
    end
  end

  p_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !adj_q && have_last_q) |-> (pf_line > last_q));

  p_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !adj_q) |-> ((pf_line > base_q) && (pf_line - base_q <= LINE_W'(dep_q))));

  p_partner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && adj_q) |-> (pf_line == (base_q ^ LINE_W'(1))));

  p_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_line[LINE_W-1:PAGE_LINES_LOG2] == base_q[LINE_W-1:PAGE_LINES_LOG2]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready && !dmd_valid) |=> (!enable || (pf_valid && $stable(pf_line))));

  p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready) |=> !(pf_valid && pf_line == $past(pf_line)));

  p_off_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !pf_valid);
endmodule

bind pnl_prefetcher pnl_checker #(
  .LINE_W(LINE_W), .PAGE_LINES_LOG2(PAGE_LINES_LOG2), .MAX_DEPTH(MAX_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .adj_mode(adj_mode), .depth(depth),
  .dmd_valid(dmd_valid), .dmd_line(dmd_line), .pf_valid(pf_valid),
  .pf_ready(pf_ready), .pf_line(pf_line)
);

// File: tb/pnl_prefetcher_tb.sv
module pnl_prefetcher_tb_top;
  localparam int LINE_W = 32;
  localparam int PG     = 6;
  localparam int MAXD   = 8;
  localparam int FD     = 4;
  localparam int DW     = $clog2(MAXD + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b1;
  logic              adj_mode = 1'b0;
  logic [DW-1:0]     depth = '0;
  logic              dmd_valid = 1'b0;
  logic [LINE_W-1:0] dmd_line = '0;
  logic              pf_ready = 1'b1;
  logic              pf_valid;
  logic [LINE_W-1:0] pf_line;

  int n_checks = 0;
  int n_fail   = 0;
  int hs_cnt   = 0;
  string cur_req = "R9";
  logic [LINE_W-1:0] pend[$];
  logic [LINE_W-1:0] recent[$];

  always #5 clk = ~clk;

  pnl_prefetcher #(.LINE_W(LINE_W), .PAGE_LINES_LOG2(PG), .MAX_DEPTH(MAXD), .FILT_DEPTH(FD)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .adj_mode(adj_mode), .depth(depth),
    .dmd_valid(dmd_valid), .dmd_line(dmd_line), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_line(pf_line)
  );

  function automatic bit in_recent(logic [LINE_W-1:0] l);
    foreach (recent[i]) if (recent[i] == l) return 1'b1;
    return 1'b0;
  endfunction

  // reference model, evaluated between edges
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      bit sk;
      logic [LINE_W-1:0] el;
      ev = 1'b0; sk = 1'b0; el = '0;
      if (enable && pend.size() > 0) begin
        if (in_recent(pend[0])) sk = 1'b1;
        else begin ev = 1'b1; el = pend[0]; end
      end
      n_checks++;
      if (pf_valid !== ev || (ev && pf_line !== el)) begin
        n_fail++;
        $display("FAIL %s: valid=%0b line=%h expected valid=%0b line=%h",
                 cur_req, pf_valid, pf_line, ev, el);
      end
      if (pf_valid && pf_ready) hs_cnt++;
      if (enable) begin
        if (ev && pf_ready) begin
          recent.push_back(pend.pop_front());
          if (recent.size() > FD) void'(recent.pop_front());
        end else if (sk) begin
          void'(pend.pop_front());
        end
        if (dmd_valid) begin
          pend.delete();
          if (adj_mode) pend.push_back(dmd_line ^ 1);
          else begin
            int d;
            d = (int'(depth) > MAXD) ? MAXD : int'(depth);
            for (int i = 1; i <= d; i++)
              if (((dmd_line + i) >> PG) == (dmd_line >> PG)) pend.push_back(dmd_line + i);
          end
        end
      end else begin
        pend.delete();
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic demand(logic [LINE_W-1:0] l, int d, bit adj);
    dmd_valid = 1'b1; dmd_line = l; depth = DW'(d); adj_mode = adj;
    @(posedge clk); #1;
    dmd_valid = 1'b0;
  endtask

  task automatic check_count(string req, int exp);
    n_checks++;
    if (hs_cnt != exp) begin
      n_fail++;
      $display("FAIL %s: transfers=%0d expected=%0d", req, hs_cnt, exp);
    end
    hs_cnt = 0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: cycles=20000 expected=done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (pf_valid !== 1'b0) begin  // R9 during reset
      n_fail++; $display("FAIL R9: valid=%0b expected=0", pf_valid);
    end
    rst_n = 1'b1;
    idle(3); hs_cnt = 0;

    cur_req = "R1"; demand(32'h100, 4, 1'b0); idle(8); check_count("R1", 4);
    cur_req = "R2"; demand(32'h300, 15, 1'b0); idle(12); check_count("R2", 8);
    demand(32'h380, 0, 1'b0); idle(4); check_count("R2", 0);
    cur_req = "R3"; demand(32'h205, 5, 1'b1); idle(4); check_count("R3", 1);
    cur_req = "R4"; demand(32'h13D, 8, 1'b0); idle(10); check_count("R4", 2);
    demand(32'h1BF, 8, 1'b0); idle(4); check_count("R4", 0);

    cur_req = "R6"; demand(32'h700, 6, 1'b0);
    for (int i = 0; i < 16; i++) begin pf_ready = (i % 3) != 0; idle(1); end
    pf_ready = 1'b1; idle(4); check_count("R6", 6);

    cur_req = "R5"; demand(32'h900, 8, 1'b0); idle(2); demand(32'hA00, 3, 1'b0);
    idle(6); check_count("R5", 6);

    cur_req = "R7"; demand(32'h500, 2, 1'b0); idle(6); check_count("R7", 2);
    demand(32'h500, 4, 1'b0); idle(8); check_count("R7", 2);

    cur_req = "R8"; enable = 1'b0; demand(32'h600, 4, 1'b0); idle(6);
    check_count("R8", 0);
    enable = 1'b1; demand(32'h640, 8, 1'b0); idle(2); enable = 1'b0; idle(4);
    enable = 1'b1; idle(4); check_count("R8", 2);

    idle(2);
    report();
  end
endmodule